// File: doc/BRIEF.md
# Settle-Window Word Synchronizer

This block carries a slowly changing multi-bit control word, such as a small mode selector, from a source with no clock relationship into a fast clock domain. The source gives no valid flag. Each bit first passes through its own two-flop synchronizer. The block then watches the whole synchronized word for a change on any bit. When a change is seen, it waits until the word has held still for a set number of fast-clock cycles. Only after that wait does it load the word into its output register, with all bits loaded in the same cycle.

Each real change of the settled word produces a single-cycle update strobe. Because the source holds each value much longer than the settle window, the window lets skew between bits die out. The block therefore never presents an output that mixes old and new bits.

Top module: `bus_settle_sync`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `word_o` is all zeros and `upd_o` is 0.
- R2: Each bit of `bus_i` passes through two fast-clock flops. A change that is presented before clock edge k, and then held, appears on `word_o` after edge k+SETTLE_CYCLES+2, and not earlier.
- R3: A change on any single bit of the synchronized word restarts the settle count from zero. `word_o` is loaded only after the synchronized word has been unchanged for SETTLE_CYCLES consecutive cycles.
- R4: All bits of `word_o` are loaded in the same cycle. `word_o` never changes in a cycle without `upd_o`, even when the input bits arrive several cycles apart.
- R5: `upd_o` is high for exactly one cycle per capture. While the input stays unchanged, the settle count holds at its limit and no further strobe occurs.
- R6: If the settled word equals the word already held on `word_o`, `word_o` keeps its value and `upd_o` stays 0. This also covers a bounce that returns to the old value.
- R7: After reset, the first value that differs from zero is captured only once the full settle window has elapsed, measured from reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_i | input | WIDTH | Raw word from the asynchronous source |
| word_o | output | WIDTH | Captured word, loaded whole |
| upd_o | output | 1 | One-cycle strobe, high in the cycle `word_o` takes a new value |

## Verification
The bench drives clean single changes held well past the window. It also drives changes whose bits arrive a few cycles apart, and these separate a whole-word capture from per-bit capture. Bounces shorter than the window show whether the count restarts on every edge. Bounces that return to the held value show whether a strobe is correctly suppressed. Changes held for exactly SETTLE_CYCLES-1 and SETTLE_CYCLES cycles after synchronization pin the capture point to the cycle, and a non-zero word held through reset tests the first capture after reset.

// File: rtl/bss_pkg.sv
package bss_pkg;
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/bss_sync2.sv
module bss_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic ff1_q, ff2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q <= 1'b0;
        ff2_q <= 1'b0;
      end else begin
        ff1_q <= d_i[b];
        ff2_q <= ff1_q;
      end
    end
    assign q_o[b] = ff2_q;
  end
endmodule

// File: rtl/bss_settle.sv
module bss_settle
  import bss_pkg::*;
#(
  parameter int WIDTH         = 2,
  parameter int SETTLE_CYCLES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  output logic             fire_o
);
  localparam int CW = cnt_width(SETTLE_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);
  localparam logic [CW-1:0] LAST  = CW'(SETTLE_CYCLES - 1);

  logic [WIDTH-1:0] dly_q;
  logic [CW-1:0]    cnt_q;
  logic             chg;

  // per-bit edge detect, OR-reduced over the word
  assign chg = |(sync_i ^ dly_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      cnt_q <= '0;
    end else begin
      dly_q <= sync_i;
      if (chg)                cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = !chg && (cnt_q == LAST);
endmodule

// File: rtl/bss_capture.sv
module bss_capture #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] word_o,
  output logic             upd_o
);
  logic [WIDTH-1:0] word_q;
  logic             upd_q;
  logic             differs;

  assign differs = (sync_i != word_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= fire_i && differs;
      if (fire_i && differs) word_q <= sync_i;
    end
  end

  assign word_o = word_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/bus_settle_sync.sv
module bus_settle_sync #(
  parameter int WIDTH         = 2,
  parameter int SETTLE_CYCLES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] word_o,
  output logic             upd_o
);
  logic [WIDTH-1:0] sync_w;
  logic             fire_w;

  bss_sync2 #(.WIDTH(WIDTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_i),
    .q_o   (sync_w)
  );

  bss_settle #(.WIDTH(WIDTH), .SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_w),
    .fire_o(fire_w)
  );

  bss_capture #(.WIDTH(WIDTH)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire_w),
    .sync_i(sync_w),
    .word_o(word_o),
    .upd_o (upd_o)
  );
endmodule

// File: rtl/bus_settle_sync_chk.sv
module bus_settle_sync_chk #(
  parameter int WIDTH         = 2,
  parameter int SETTLE_CYCLES = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] sync_w,
  input logic [WIDTH-1:0] word_o,
  input logic             upd_o
);
  logic [WIDTH-1:0] prev_q;
  int unsigned      still_q;

  // cycles the synchronized word has held, counted independently
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      still_q <= 0;
    end else begin
      prev_q <= sync_w;
      if (sync_w != prev_q)              still_q <= 0;
      else if (still_q < SETTLE_CYCLES + 4) still_q <= still_q + 1;
    end
  end

  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  assert_word_moves_with_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_o != $past(word_o)) |-> upd_o);

  assert_strobe_means_new_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (word_o != $past(word_o)));

  assert_window_elapsed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (still_q >= SETTLE_CYCLES));
endmodule

bind bus_settle_sync bus_settle_sync_chk #(.WIDTH(WIDTH), .SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sync_w(sync_w),
  .word_o(word_o),
  .upd_o (upd_o)
);

// File: tb/bus_settle_sync_test.sv
module bus_settle_sync_test;
  localparam int W = 2;
  localparam int S = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] bus = '0;
  logic [W-1:0] word;
  logic         upd;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string req = "R1";

  // reference model state
  int p1 = 0, p2 = 0, p3 = 0;
  int still = 0;
  int m_word = 0;
  int m_upd = 0;
  int strobes = 0;

  always #10 clk = ~clk;

  bus_settle_sync #(.WIDTH(W), .SETTLE_CYCLES(S)) uut (
    .clk_i (clk),
    .rst_ni(rst_n),
    .bus_i (bus),
    .word_o(word),
    .upd_o (upd)
  );

  // behavioural reference: bus seen two edges late, capture after S quiet cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 0; p2 = 0; p3 = 0; still = 0; m_word = 0; m_upd = 0;
    end else begin
      int cur;
      cur = p2;
      m_upd = 0;
      if (cur != p3) still = 0;
      else begin
        if (still == S - 1 && cur != m_word) begin
          m_word = cur;
          m_upd = 1;
        end
        if (still < S) still = still + 1;
      end
      p3 = p2; p2 = p1; p1 = int'(bus);
      cycles++;
    end
  end

  task automatic compare();
    vectors++;
    if (int'(word) != m_word || int'(upd) != m_upd) begin
      errors++;
      $display("FAIL %s: word=%0d upd=%0d expected word=%0d upd=%0d",
               req, word, upd, m_word, m_upd);
    end
    if (upd) strobes++;
  endtask

  task automatic hold(input int val, input int n);
    for (int i = 0; i < n; i++) begin
      bus = W'(val);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
    finish_run();
  end

  initial begin
    // R7: non-zero word held through reset
    req = "R1";
    bus = 2'b11;
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
    req = "R7";
    hold(3, S + 6);

    // R2: clean single change, exact latency
    req = "R2";
    strobes = 0;
    hold(1, 1);
    hold(1, S + 1);
    vectors++;
    if (word != 2'b11) begin
      errors++;
      $display("FAIL R2: early word=%0d expected 3", word);
    end
    hold(1, 2);
    vectors++;
    if (word != 2'b01 || strobes != 1) begin
      errors++;
      $display("FAIL R2: word=%0d strobes=%0d expected word=1 strobes=1", word, strobes);
    end

    // R5: long hold, no repeat strobe
    req = "R5";
    strobes = 0;
    hold(1, 3 * S);
    vectors++;
    if (strobes != 0) begin
      errors++;
      $display("FAIL R5: strobes=%0d expected 0", strobes);
    end

    // R3: bounces shorter than the window restart it
    req = "R3";
    for (int k = 0; k < 4; k++) begin
      hold(2, S / 2);
      hold(0, S / 3);
    end
    hold(2, S - 1);
    hold(2, S + 5);

    // R4: bits arrive several cycles apart
    req = "R4";
    strobes = 0;
    hold(3, 3);
    hold(1, 4);
    hold(1, S + 6);
    vectors++;
    if (strobes != 1 || word != 2'b01) begin
      errors++;
      $display("FAIL R4: strobes=%0d word=%0d expected 1 and 1", strobes, word);
    end

    // R6: bounce back to held value, no strobe
    req = "R6";
    strobes = 0;
    hold(2, S - 2);
    hold(1, S + 6);
    hold(3, 5);
    hold(1, S + 6);
    vectors++;
    if (strobes != 0 || word != 2'b01) begin
      errors++;
      $display("FAIL R6: strobes=%0d word=%0d expected 0 and 1", strobes, word);
    end

    // R3: boundary, hold one short of the window then exactly the window
    req = "R3";
    hold(0, S - 1);
    hold(3, S + 6);
    hold(2, S);
    hold(0, S + 6);

    // R1: reset mid-run clears state
    req = "R1";
    bus = 2'b10;
    rst_n = 1'b0;
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    req = "R7";
    hold(2, S + 8);

    finish_run();
  end
endmodule